// File: doc/BRIEF.md
# Estimator Table Up-Scale Converter

This block moves a set of per-flow counters from one shared estimate table to a coarser replacement table. Each flow counter is a small pointer into the active table, and the table holds the estimate value for each index. While the counting path runs, the block watches every pointer it writes. When a pointer reaches a programmed threshold index, the block raises a request, because the counters are about to run out of range. Higher-level logic then prepares the replacement table, built for a slightly larger relative error, and issues a start.

During the conversion the block walks the pointer memory one flow at a time. For each flow it reads the pointer and looks up the old estimate. A binary search over the new table finds the bracketing pair of entries. The block then rounds between the two entries at random, with a probability that keeps the expected value of the estimate unchanged, and writes the new pointer back. When the last flow is done, the new table becomes the active one. The threshold must then be reloaded before another request can be raised.

Top module: `upscale_conv`

## Requirements
- R1: When armed and idle, a watched pointer write whose value is greater than or equal to the threshold sets `up_req_o` at the next clock edge. The request stays high until a start is accepted, and an accepted start clears it. Watched writes made while busy are ignored.
- R2: A watched pointer write below the threshold leaves `up_req_o` low.
- R3: The edge that follows the `done_o` pulse disarms the trigger. Watched writes then raise no request until `thr_we_i` loads a threshold, and that load re-arms the trigger.
- R4: An accepted start makes `busy_o` high from the next edge for exactly N_FLOWS*(PTR_W+19) cycles. `done_o` is high for one cycle, in the first cycle in which `busy_o` is low again.
- R5: Flows are rewritten in ascending order, 0 to N_FLOWS-1, and each flow is written exactly once per conversion.
- R6: For old estimate v, the index j is the largest index of the new table with new[j] <= v. The rewritten pointer is j or j+1. Entry 0 of every table is zero, and the entries strictly increase.
- R7: An old estimate equal to a new entry maps to that entry's index with certainty.
- R8: An old estimate of zero maps to index 0.
- R9: Otherwise the fraction f = floor((v-new[j])*65536/(new[j+1]-new[j])) is formed. The pointer becomes j+1 when the 16-bit random sample s < f, and j otherwise.
- R10: An old estimate at or above the last new entry maps to index 2^PTR_W-1.
- R11: `act_tbl_o` is 0 after reset and toggles when each conversion completes, together with `done_o`.
- R12: `start_i` has no effect while `busy_o` is high.
- R13: The random sample comes from a 16-bit register that holds SEED after reset. Each advance shifts it left by one bit and puts bit15^bit13^bit12^bit10 into bit 0. It advances once per rewritten pointer, and the value used for a decision is the one held before that advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin conversion (honoured when idle) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| up_req_o | output | 1 | Up-scale request |
| act_tbl_o | output | 1 | Selects which of two tables is active |
| thr_we_i | input | 1 | Load threshold and re-arm |
| thr_i | input | PTR_W | Threshold index |
| ptr_wr_en_i | input | 1 | Watched pointer write strobe |
| ptr_wr_data_i | input | PTR_W | Watched pointer write value |
| pm_addr_o | output | FLOW_W | Pointer memory address |
| pm_rdata_i | input | PTR_W | Pointer memory read data (combinational) |
| pm_we_o | output | 1 | Pointer memory write enable |
| pm_wdata_o | output | PTR_W | Pointer memory write data |
| old_idx_o | output | PTR_W | Old table read index |
| old_val_i | input | VAL_W | Old table read value (combinational) |
| new_idx_o | output | PTR_W | New table read index |
| new_val_i | input | VAL_W | New table read value (combinational) |

## Verification
The bench builds the block with N_FLOWS=8, PTR_W=3 (an eight-entry table) and VAL_W=16. Starting the pointers at 0..7 therefore reaches every old-table index in a single pass. That pass covers the zero estimate, exact hits, fractional positions between bracketing entries, and, in a second pass, estimates that saturate at the top entry. The two back-to-back conversions also exercise the active-table swap, the disarm and re-arm of the trigger, and a random sequence that carries over from one pass to the next.

// File: rtl/upscale_pkg.sv
package upscale_pkg;
  localparam int FRAC_W = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_SRCH,
    S_HI,
    S_DIV,
    S_WR
  } conv_state_e;
endpackage

// File: rtl/upscale_lfsr.sv
module upscale_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  output logic [15:0] smp_o
);
  logic [15:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= SEED;
    else if (adv_i) sr_q <= {sr_q[14:0], sr_q[15] ^ sr_q[13] ^ sr_q[12] ^ sr_q[10]};
  end

  assign smp_o = sr_q;

  assert_lfsr_live_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o != 16'h0);
endmodule

// File: rtl/upscale_div.sv
module upscale_div #(
  parameter int VAL_W = 32,
  parameter int Q_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VAL_W-1:0] num_i,
  input  logic [VAL_W-1:0] den_i,
  input  logic             step_i,
  output logic [Q_W-1:0]   quot_o
);
  logic [VAL_W-1:0] rem_q, den_q;
  logic [Q_W-1:0]   quot_q;
  logic             ok_q;
  logic [VAL_W:0]   rem2, diff;
  logic             ge;

  always_comb begin
    rem2 = {rem_q, 1'b0};
    ge   = rem2 >= {1'b0, den_q};
    diff = rem2 - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
      ok_q   <= 1'b0;
    end else if (load_i) begin
      rem_q  <= num_i;
      den_q  <= den_i;
      quot_q <= '0;
      ok_q   <= num_i < den_i;
    end else if (step_i) begin
      rem_q  <= ge ? diff[VAL_W-1:0] : rem2[VAL_W-1:0];
      quot_q <= {quot_q[Q_W-2:0], ge};
    end
  end

  assign quot_o = quot_q;

  // remainder stays below divisor for a proper fraction
  assert_rem_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> rem_q < den_q);
endmodule

// File: rtl/upscale_trigger.sv
module upscale_trigger #(
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_we_i,
  input  logic [PTR_W-1:0] thr_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_data_i,
  input  logic             busy_i,
  input  logic             clr_i,
  input  logic             done_i,
  output logic             req_o
);
  logic [PTR_W-1:0] thr_q;
  logic             armed_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q   <= '0;
      armed_q <= 1'b0;
    end else if (thr_we_i) begin
      thr_q   <= thr_i;
      armed_q <= 1'b1;
    end else if (done_i) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else if (clr_i) req_q <= 1'b0;
    else if (armed_q && !busy_i && wr_en_i && (wr_data_i >= thr_q)) req_q <= 1'b1;
  end

  assign req_o = req_q;

  assert_disarm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !thr_we_i |=> !armed_q);
  assert_no_req_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !$rose(req_o));
endmodule

// File: rtl/upscale_conv.sv
module upscale_conv
  import upscale_pkg::*;
#(
  parameter int          N_FLOWS = 64,
  parameter int          PTR_W   = 4,
  parameter int          VAL_W   = 32,
  parameter logic [15:0] SEED    = 16'hACE1,
  localparam int         FLOW_W  = $clog2(N_FLOWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              up_req_o,
  output logic              act_tbl_o,
  input  logic              thr_we_i,
  input  logic [PTR_W-1:0]  thr_i,
  input  logic              ptr_wr_en_i,
  input  logic [PTR_W-1:0]  ptr_wr_data_i,
  output logic [FLOW_W-1:0] pm_addr_o,
  input  logic [PTR_W-1:0]  pm_rdata_i,
  output logic              pm_we_o,
  output logic [PTR_W-1:0]  pm_wdata_o,
  output logic [PTR_W-1:0]  old_idx_o,
  input  logic [VAL_W-1:0]  old_val_i,
  output logic [PTR_W-1:0]  new_idx_o,
  input  logic [VAL_W-1:0]  new_val_i
);
  localparam int CNT_W = $clog2(FRAC_W);

  conv_state_e       state_q;
  logic [FLOW_W-1:0] flow_q;
  logic [PTR_W-1:0]  j_q, sbit_q, cand;
  logic [VAL_W-1:0]  v_q, lo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              at_top_q, done_q, act_q;
  logic              start_acc, last_flow, up;
  logic [15:0]       smp;
  logic [FRAC_W-1:0] frac;

  assign start_acc = start_i && (state_q == S_IDLE);
  assign last_flow = flow_q == FLOW_W'(N_FLOWS - 1);
  assign cand      = j_q | sbit_q;
  assign up        = !at_top_q && (smp < frac);

  assign busy_o     = state_q != S_IDLE;
  assign done_o     = done_q;
  assign act_tbl_o  = act_q;
  assign pm_addr_o  = flow_q;
  assign old_idx_o  = pm_rdata_i;
  assign new_idx_o  = (state_q == S_SRCH) ? cand : PTR_W'(j_q + 1'b1);
  assign pm_we_o    = state_q == S_WR;
  assign pm_wdata_o = j_q + PTR_W'(up);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      flow_q   <= '0;
      j_q      <= '0;
      sbit_q   <= '0;
      v_q      <= '0;
      lo_q     <= '0;
      cnt_q    <= '0;
      at_top_q <= 1'b0;
      done_q   <= 1'b0;
      act_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_acc) begin
          flow_q  <= '0;
          state_q <= S_RD;
        end
        S_RD: begin
          v_q     <= old_val_i;
          j_q     <= '0;
          lo_q    <= '0;
          sbit_q  <= {1'b1, {(PTR_W-1){1'b0}}};
          state_q <= S_SRCH;
        end
        S_SRCH: begin
          if (new_val_i <= v_q) begin
            j_q  <= cand;
            lo_q <= new_val_i;
          end
          sbit_q <= sbit_q >> 1;
          if (sbit_q[0]) state_q <= S_HI;
        end
        S_HI: begin
          at_top_q <= &j_q;
          cnt_q    <= '0;
          state_q  <= S_DIV;
        end
        S_DIV: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(FRAC_W - 1)) state_q <= S_WR;
        end
        S_WR: begin
          if (last_flow) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            act_q   <= ~act_q;
          end else begin
            flow_q  <= flow_q + 1'b1;
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  upscale_div #(.VAL_W(VAL_W), .Q_W(FRAC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == S_HI),
    .num_i  (v_q - lo_q),
    .den_i  (new_val_i - lo_q),
    .step_i (state_q == S_DIV),
    .quot_o (frac)
  );

  upscale_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (state_q == S_WR),
    .smp_o  (smp)
  );

  upscale_trigger #(.PTR_W(PTR_W)) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_we_i  (thr_we_i),
    .thr_i     (thr_i),
    .wr_en_i   (ptr_wr_en_i),
    .wr_data_i (ptr_wr_data_i),
    .busy_i    (busy_o),
    .clr_i     (start_acc),
    .done_i    (done_q),
    .req_o     (up_req_o)
  );

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_flow_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD) && ($past(state_q) == S_WR) |-> pm_addr_o == FLOW_W'($past(pm_addr_o) + 1'b1));
  assert_exact_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we_o && (lo_q == v_q) |-> pm_wdata_o == j_q);
  assert_top_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we_o && at_top_q |-> &pm_wdata_o);
endmodule

// File: tb/upscale_conv_tb.sv
module upscale_conv_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N   = 8;
  localparam int PW  = 3;
  localparam int VW  = 16;
  localparam int L   = 1 << PW;
  localparam int FW  = 3;
  localparam int TOT = N * (PW + 19);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, thr_we = 1'b0, ptr_wr_en = 1'b0;
  logic [PW-1:0] thr = '0, ptr_wr_data = '0;
  logic          busy, done, up_req, act, pm_we;
  logic [FW-1:0] pm_addr;
  logic [PW-1:0] pm_rdata, pm_wdata, old_idx, new_idx;
  logic [VW-1:0] old_val, new_val;

  logic [PW-1:0] ptr_mem [N];
  logic [VW-1:0] tbl [2][L];

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign pm_rdata = ptr_mem[pm_addr];
  assign old_val  = tbl[act][old_idx];
  assign new_val  = tbl[!act][new_idx];

  upscale_conv #(.N_FLOWS(N), .PTR_W(PW), .VAL_W(VW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .up_req_o(up_req), .act_tbl_o(act), .thr_we_i(thr_we), .thr_i(thr),
    .ptr_wr_en_i(ptr_wr_en), .ptr_wr_data_i(ptr_wr_data), .pm_addr_o(pm_addr),
    .pm_rdata_i(pm_rdata), .pm_we_o(pm_we), .pm_wdata_o(pm_wdata),
    .old_idx_o(old_idx), .old_val_i(old_val), .new_idx_o(new_idx), .new_val_i(new_val)
  );

  task automatic check(input bit ok, input string tag, input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  // behavioural reference of control outputs
  logic m_busy, m_done, m_req, m_armed, m_act;
  logic [PW-1:0] m_thr;
  int m_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_req <= 0; m_armed <= 0; m_act <= 0; m_thr <= '0; m_rem <= 0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_rem == 1) begin m_busy <= 1'b0; m_done <= 1'b1; m_act <= !m_act; end
        m_rem <= m_rem - 1;
      end else if (start) begin
        m_busy <= 1'b1; m_rem <= TOT;
      end
      if (thr_we) begin m_armed <= 1'b1; m_thr <= thr; end
      else if (m_done) m_armed <= 1'b0;
      if (start && !m_busy) m_req <= 1'b0;
      else if (m_armed && !m_busy && ptr_wr_en && ptr_wr_data >= m_thr) m_req <= 1'b1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(busy == m_busy, "R4 busy", busy, m_busy);
    check(done == m_done, "R4 done", done, m_done);
    check(up_req == m_req, "R1 up_req", up_req, m_req);
    check(act == m_act, "R11 act_tbl", act, m_act);
  end

  int wr_seq = 0;
  always @(posedge clk) if (rst_n && pm_we) begin
    check(int'(pm_addr) == wr_seq, "R5 write order", pm_addr, wr_seq);
    if (pm_we) ptr_mem[pm_addr] <= pm_wdata;
    wr_seq = (wr_seq + 1) % N;
  end

  // reference random sequence (R13)
  logic [15:0] m_lfsr = 16'hACE1;
  int          exp_ptr [N];
  string       exp_tag [N];

  task automatic predict();
    for (int k = 0; k < N; k++) begin
      int v, j, lo, hi;
      longint f;
      v = int'(tbl[act][ptr_mem[k]]);
      j = 0;
      for (int i = 1; i < L; i++) if (int'(tbl[!act][i]) <= v) j = i;
      lo = int'(tbl[!act][j]);
      if (j == L - 1) begin
        exp_ptr[k] = L - 1; exp_tag[k] = "R10";
      end else begin
        hi = int'(tbl[!act][j+1]);
        f = (longint'(v - lo) << 16) / longint'(hi - lo);
        exp_ptr[k] = j + ((longint'(m_lfsr) < f) ? 1 : 0);
        exp_tag[k] = (v == 0) ? "R8" : (v == lo) ? "R7" : "R9 R13";
      end
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  endtask

  task automatic watch_wr(input logic [PW-1:0] d);
    @(negedge clk); ptr_wr_en = 1'b1; ptr_wr_data = d;
    @(negedge clk); ptr_wr_en = 1'b0;
  endtask

  task automatic load_thr(input logic [PW-1:0] t);
    @(negedge clk); thr_we = 1'b1; thr = t;
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic convert();
    int cyc;
    predict();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(up_req == 1'b0, "R1 start clears request", up_req, 0);
    cyc = 1;
    while (!done && cyc < 2000) begin
      start = (cyc == 20);  // R12: start while busy is ignored
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == TOT + 1, "R4 R12 busy length", cyc - 1, TOT);
    for (int k = 0; k < N; k++)
      check(int'(ptr_mem[k]) == exp_ptr[k], {exp_tag[k], " R6 remapped pointer"}, ptr_mem[k], exp_ptr[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a [L] = '{0, 1, 3, 5, 9, 13, 20, 40};
    int b [L] = '{0, 2, 5, 9, 16, 30, 60, 100};
    int c [L] = '{0, 3, 7, 15, 31, 50, 70, 90};
    for (int i = 0; i < L; i++) begin tbl[0][i] = VW'(a[i]); tbl[1][i] = VW'(b[i]); end
    for (int k = 0; k < N; k++) ptr_mem[k] = PW'(k);
    repeat (3) @(negedge clk);
    check({busy, done, up_req, act} == 4'b0, "R4 R11 reset state", {busy, done, up_req, act}, 0);
    rst_n = 1'b1;

    load_thr(3'd6);
    watch_wr(3'd3);
    check(up_req == 1'b0, "R2 below threshold", up_req, 0);
    watch_wr(3'd6);
    check(up_req == 1'b1, "R1 threshold reached", up_req, 1);

    convert();  // old A -> new B: zero, exact hits, fractional
    check(act == 1'b1, "R11 table swap", act, 1);

    watch_wr(3'd7);
    check(up_req == 1'b0, "R3 disarmed after done", up_req, 0);
    load_thr(3'd5);
    watch_wr(3'd6);
    check(up_req == 1'b1, "R3 re-armed by reload", up_req, 1);

    for (int i = 0; i < L; i++) tbl[0][i] = VW'(c[i]);
    ptr_mem[7] = 3'd7;
    ptr_mem[6] = 3'd6;
    convert();  // old B -> new C: top saturation
    check(act == 1'b0, "R11 table swap back", act, 0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule